// File: doc/BRIEF.md
# Dual-Edge Fan PWM Channel

This block drives one fan-control PWM pin. The system clock first passes through a two-stage prescaler. One stage divides by a power of two and the other divides linearly. The prescaled tick then advances a period counter, which runs from 0 up to a programmable 8-bit limit and wraps. Two independent 8-bit compare points set where the pulse sits within each period: the output turns on at the rising point and turns off at the falling point.

Software sets the on-time from a requested level in the range 0..255 as level × period / 255. It then programs a rising point of 0 and a falling point equal to that on-time. A level of 0 is realised by clearing the enable, which forces the pin low. A falling point equal to the period gives a constant-high output. The compare points, the period and both divider settings are captured only at the start of a period, so a change made mid-cycle never produces a runt pulse. A one-clock strobe marks the start of every period.

Top module: `pwm_dual_edge`

## Requirements
- R1: While reset is asserted, `pwm_o` and `cycle_start` are both 0.
- R2: While `en` is 0, `pwm_o` is 0 in the same cycle and `cycle_start` is 0 from the next clock edge. After `en` rises again, counting restarts at count 0 with fresh settings.
- R3: Each count lasts D clocks. D = F × 2^`div_hi`, where F is 1 when `div_lo` is 0 and 2 × `div_lo` otherwise.
- R4: A period spans `period`+1 counts, so D × (`period`+1) clocks. At the first clock edge that samples `en`=1, the count becomes 0 and `cycle_start` goes high for exactly one clock. The strobe repeats at the start of every later period.
- R5: With rise point r less than fall point f, `pwm_o` is 1 while the count c satisfies r ≤ c < f, and 0 otherwise.
- R6: When the rise and fall points are equal, `pwm_o` stays 0 for the whole period.
- R7: When f equals `period` and r < f, the output is also high at count `period`. With r = 0 this makes `pwm_o` constantly high.
- R8: When r is greater than f, `pwm_o` stays 0.
- R9: Rise, fall, period and divider inputs are captured only at period start. A change made mid-period takes effect from the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low forces the output low |
| div_hi | input | DIV_W | Power-of-two prescaler exponent |
| div_lo | input | DIV_W | Linear prescaler setting (0 means divide by 1, N means divide by 2N) |
| period | input | CNT_W | Last count value of a period |
| rise_pt | input | CNT_W | Count at which the output turns on |
| fall_pt | input | CNT_W | Count at which the output turns off |
| pwm_o | output | 1 | PWM output pin |
| cycle_start | output | 1 | One-clock strobe at the start of each period |

## Verification
The clock edge that first samples `en` high is taken as cycle 0. The count and the strobe become visible right after that edge, and `pwm_o` follows the count with no further register in between. From that edge on, the bench computes the expected pin level and strobe for each cycle t, using count = (t / D) mod (`period`+1). It queues one expected pair per clock just after each rising edge, and the monitor compares that pair against the outputs at the following falling edge. Mid-run changes to the compare points are applied just after an edge, so they are sampled on the next edge. The model switches to the new points only at the next cycle where t is a multiple of the period length. Disabling is done after the queue has drained, and the disabled cycles are queued from the next edge onward.

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge #(
  parameter int DIV_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_hi,
  input  logic [DIV_W-1:0] div_lo,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] rise_pt,
  input  logic [CNT_W-1:0] fall_pt,
  output logic             pwm_o,
  output logic             cycle_start
);
  localparam int PRE_W = DIV_W + (1 << DIV_W);

  logic             run, strobe;
  logic [PRE_W-1:0] presc, lin_fac, div_last;
  logic [CNT_W-1:0] cnt, p_l, r_l, f_l;
  logic [DIV_W-1:0] hi_l, lo_l;
  logic             tick, wrap, window;

  assign lin_fac  = (lo_l == '0) ? PRE_W'(1) : PRE_W'({lo_l, 1'b0});
  assign div_last = (lin_fac << hi_l) - PRE_W'(1);
  assign tick     = (presc == div_last);
  assign wrap     = tick && (cnt == p_l);
  assign window   = ((cnt >= r_l) && (cnt < f_l)) ||
                    ((f_l == p_l) && (r_l < f_l) && (cnt == p_l));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; strobe <= 1'b0; presc <= '0; cnt <= '0;
      p_l <= '0; r_l <= '0; f_l <= '0; hi_l <= '0; lo_l <= '0;
    end else if (!en) begin
      run <= 1'b0; strobe <= 1'b0; presc <= '0; cnt <= '0;
    end else if (!run || wrap) begin
      run <= 1'b1; strobe <= 1'b1; presc <= '0; cnt <= '0;
      p_l <= period; r_l <= rise_pt; f_l <= fall_pt;
      hi_l <= div_hi; lo_l <= div_lo;
    end else begin
      strobe <= 1'b0;
      if (tick) begin
        presc <= '0;
        cnt   <= cnt + CNT_W'(1);
      end else begin
        presc <= presc + PRE_W'(1);
      end
    end
  end

  assign pwm_o       = en & run & window;
  assign cycle_start = strobe;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= p_l)); // R4
  AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cycle_start); // R4
  AST_HOLD_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cycle_start) |-> ($stable(r_l) && $stable(f_l) && $stable(p_l))); // R9
  AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (r_l == f_l)) |-> !pwm_o); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !cycle_start); // R2
endmodule

// File: tb/test_pwm_dual_edge.sv
`timescale 1ns/1ps
module test_pwm_dual_edge;
  logic clk = 0, rst_n = 0, en = 0;
  logic [3:0] div_hi = 0, div_lo = 0;
  logic [7:0] period = 0, rise_pt = 0, fall_pt = 0;
  logic pwm_o, cycle_start;
  int checks = 0, errors = 0;
  bit    q_pwm[$];
  bit    q_stb[$];
  string q_tag[$];

  always #5 clk = ~clk;

  pwm_dual_edge i_pwm_dual_edge (
    .clk(clk), .rst_n(rst_n), .en(en), .div_hi(div_hi), .div_lo(div_lo),
    .period(period), .rise_pt(rise_pt), .fall_pt(fall_pt),
    .pwm_o(pwm_o), .cycle_start(cycle_start));

  always @(negedge clk) begin
    if (q_pwm.size() > 0) begin
      bit ep, es; string tg;
      ep = q_pwm.pop_front(); es = q_stb.pop_front(); tg = q_tag.pop_front();
      checks++;
      if (pwm_o !== ep) begin
        errors++;
        $display("FAIL %s pwm_o got %b exp %b at %0t", tg, pwm_o, ep, $time);
      end
      checks++;
      if (cycle_start !== es) begin
        errors++;
        $display("FAIL R4 (%s) cycle_start got %b exp %b at %0t", tg, cycle_start, es, $time);
      end
    end
  end

  task automatic run_case(input int hi, lo, p, r, f, r2, f2, k, n, input string tg);
    int d, len, lr, lf, cr, cf, c;
    bit ep;
    d = ((lo == 0) ? 1 : 2 * lo) << hi;
    len = d * (p + 1);
    lr = 0; lf = 0;
    @(posedge clk); #3;
    div_hi = 4'(hi); div_lo = 4'(lo); period = 8'(p);
    rise_pt = 8'(r); fall_pt = 8'(f); en = 1;
    for (int t = 0; t < n; t++) begin
      @(posedge clk); #1;
      cr = (t >= k) ? r2 : r;
      cf = (t >= k) ? f2 : f;
      if (t % len == 0) begin lr = cr; lf = cf; end
      c = (t / d) % (p + 1);
      ep = ((c >= lr) && (c < lf)) || ((lf == p) && (lr < lf) && (c == p));
      q_pwm.push_back(ep); q_stb.push_back(t % len == 0); q_tag.push_back(tg);
      #2;
      if (t + 1 == k) begin rise_pt = 8'(r2); fall_pt = 8'(f2); end
    end
    @(negedge clk); #1; en = 0;
    for (int t = 0; t < 6; t++) begin
      @(posedge clk); #1;
      q_pwm.push_back(1'b0); q_stb.push_back(1'b0); q_tag.push_back("R2");
    end
    @(negedge clk); #1;
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    en = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (pwm_o !== 1'b0 || cycle_start !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs in reset got %b%b exp 00", pwm_o, cycle_start);
    end
    en = 0;
    @(negedge clk); rst_n = 1;
    // R5 basic window, divide by 1
    run_case(0, 0, 9, 2, 6, 2, 6, 1000, 35, "R5");
    // R3 prescaler: lo=3 -> 6, hi=1 -> x2
    run_case(1, 3, 4, 1, 3, 1, 3, 1000, 130, "R3");
    // R3 with lo=1, hi=2 and R6 equal points
    run_case(2, 1, 5, 3, 3, 3, 3, 1000, 100, "R6");
    // R7 full-on
    run_case(0, 1, 7, 0, 7, 0, 7, 1000, 40, "R7");
    // R8 rise after fall
    run_case(0, 0, 9, 6, 2, 6, 2, 1000, 25, "R8");
    // R9 mid-period change takes effect next period
    run_case(0, 0, 9, 1, 4, 5, 8, 13, 40, "R9");
    // R7 partial: fall at period, rise later
    run_case(0, 0, 6, 3, 6, 3, 6, 1000, 21, "R7");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule